// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and the memories and video devices around it. On every bus cycle it raises at most one chip select, computes the physical address for the program ROM, and qualifies the cycle with a read or write strobe. It owns two registers that the CPU writes through ordinary bus cycles:

- The **bank register** picks one 16 KB ROM page from a set of twenty. It also decides whether a 4 KB window holds banked work RAM or the first zoom chip together with palette RAM.
- The **video-control register** drives two coin-counter pins. It also switches reads in both zoom-chip windows over to the chips' ROM ports.

Decode is purely combinational from the address, the direction and the two registers, so the CPU sees a new mapping on the very next cycle after the register write. The bus side is a plain cycle qualifier (`bus_valid`) with no ready: every cycle completes in one clock, so there is no back-pressure to manage. When a read hits nothing, the block flags open bus and offers 0xFF for the system read mux.

Top module: `memmap_bank_decoder`

## Requirements
- R1: After reset the ROM page is 0, the 0x1000–0x1FFF window holds banked work RAM, zoom ROM-read mode is off and `coin_cnt` is 0.
- R2: Any access to 0x0000–0x0FFF selects fixed work RAM (select bit 0), whatever the register state.
- R3: A write to 0x3002 takes its bits 4:0 as the new ROM page from the next clock. A read in 0x4000–0x7FFF raises select bit 16, and `rom_addr` = page × 0x4000 + (address − 0x4000).
- R4: A page value of 20 or more is discarded and the previous page is kept, while bit 5 of the same write still applies. Bits 7:6 of a bank write have no effect.
- R5: With bank bit 5 clear, 0x1000–0x1FFF selects banked work RAM (bit 1). With it set, 0x1000–0x17FF selects zoom chip 1 and 0x1800–0x1FFF selects palette RAM (bit 4) for both reads and writes.
- R6: A read in 0x8000–0xFFFF raises select bit 17 with `rom_addr` = 0x48000 + (address − 0x8000). In all other cycles `rom_addr` is 0.
- R7: A write to 0x3003 loads its bits 1:0 onto `coin_cnt` from the next clock.
- R8: Bit 4 of the 0x3003 write enables ROM-read mode. In that mode a read in zoom chip 1's window raises bit 3 instead of bit 2, and a read in zoom chip 2's window (0x2800–0x2FFF) raises bit 8 instead of bit 7. Writes to either window always raise the normal select (2 or 7).
- R9: 0x2000–0x2007 raises bit 5 (sprite control) and 0x2400–0x27FF raises bit 6 (sprite RAM), for reads and writes.
- R10: The following accesses each raise one select:

  | Access | Select bit |
  |---|---|
  | write 0x3000 (sound latch) | 9 |
  | write 0x3001 (sound interrupt) | 10 |
  | write 0x3002 (bank register) | 11 |
  | write 0x3003 (video control) | 12 |
  | write 0x3700 or 0x3702 (analog select) | 13 |
  | read 0x3701 (digital input) | 14 |
  | read 0x3702 (analog data) | 15 |

  The opposite direction at these addresses is unmapped.
- R11: `dev_sel` is 18 bits wide and never has more than one bit set. `rd_strobe` or `wr_strobe` follows the cycle direction only when a select is raised, and an idle cycle (`bus_valid` low) raises nothing.
- R12: A valid cycle matching no region raises no select and no strobe. For a read it also raises `open_bus_en` with `open_bus_data` = 0xFF; otherwise `open_bus_data` is 0. Writes to ROM space are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A CPU bus cycle is present this clock |
| bus_we | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| dev_sel | output | 18 | One-hot device selects (bit map in R2–R10) |
| rd_strobe | output | 1 | Mapped read in progress |
| wr_strobe | output | 1 | Mapped write in progress |
| rom_addr | output | 19 | Physical program-ROM byte address |
| open_bus_en | output | 1 | Read hit no device |
| open_bus_data | output | 8 | Fill value for an unmapped read |
| coin_cnt | output | 2 | Coin-counter drives |

## Verification
Selects, strobes, `rom_addr` and the open-bus pair are combinational, so each result is due in the same cycle as its address. The bench drives every cycle at the falling edge and compares shortly after, well before the next rising edge. Register writes, and with them `coin_cnt` and every later mapping, change at the rising edge that closes the write cycle. The reference model therefore applies a write only after that edge, and the next compared cycle is the first to expect the new state. Back-to-back write-then-read pairs at the page limit and at the window boundaries pin this one-cycle latency exactly.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int SEL_COUNT     = 18;
  localparam int SEL_WRAM_FIX  = 0;
  localparam int SEL_WRAM_BANK = 1;
  localparam int SEL_ZOOM1     = 2;
  localparam int SEL_ZOOM1_ROM = 3;
  localparam int SEL_PALETTE   = 4;
  localparam int SEL_SPR_CTRL  = 5;
  localparam int SEL_SPR_RAM   = 6;
  localparam int SEL_ZOOM2     = 7;
  localparam int SEL_ZOOM2_ROM = 8;
  localparam int SEL_SND_LATCH = 9;
  localparam int SEL_SND_IRQ   = 10;
  localparam int SEL_BANK_REG  = 11;
  localparam int SEL_VCTL_REG  = 12;
  localparam int SEL_AN_SEL    = 13;
  localparam int SEL_DIN       = 14;
  localparam int SEL_AN_DATA   = 15;
  localparam int SEL_ROM_BANK  = 16;
  localparam int SEL_ROM_FIX   = 17;

  localparam int ZOOM_COUNT = 2;

  typedef logic [SEL_COUNT-1:0] sel_vec_t;
endpackage

// File: rtl/mmd_ctrl_regs.sv
module mmd_ctrl_regs #(
  parameter int          ADDR_W        = 16,
  parameter int          PAGE_BITS     = 5,
  parameter int          PAGE_COUNT    = 20,
  parameter logic [15:0] BANK_REG_ADDR = 16'h3002,
  parameter logic [15:0] VCTL_REG_ADDR = 16'h3003
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [PAGE_BITS-1:0] page_field,
  input  logic                 win_field,
  input  logic [1:0]           coin_field,
  input  logic                 romrd_field,
  output logic [PAGE_BITS-1:0] page_q,
  output logic                 win_periph_q,
  output logic                 zoom_romrd_q,
  output logic [1:0]           coin_q
);
  localparam logic [PAGE_BITS:0] PAGE_LIMIT = (PAGE_BITS+1)'(PAGE_COUNT);

  logic bank_wr, vctl_wr, page_ok;

  assign bank_wr = bus_valid && bus_we && (bus_addr == ADDR_W'(BANK_REG_ADDR));
  assign vctl_wr = bus_valid && bus_we && (bus_addr == ADDR_W'(VCTL_REG_ADDR));
  assign page_ok = ({1'b0, page_field} < PAGE_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q       <= '0;
      win_periph_q <= 1'b0;
    end else if (bank_wr) begin
      win_periph_q <= win_field;
      if (page_ok) page_q <= page_field;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zoom_romrd_q <= 1'b0;
      coin_q       <= 2'b00;
    end else if (vctl_wr) begin
      zoom_romrd_q <= romrd_field;
      coin_q       <= coin_field;
    end
  end
endmodule

// File: rtl/mmd_region_decode.sv
module mmd_region_decode
  import mmd_pkg::*;
(
  input  logic        bus_valid,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic        win_periph,
  input  logic        zoom_romrd,
  output sel_vec_t    sel
);
  localparam int ZOOM_NORM_IDX [ZOOM_COUNT] = '{SEL_ZOOM1, SEL_ZOOM2};
  localparam int ZOOM_ROM_IDX  [ZOOM_COUNT] = '{SEL_ZOOM1_ROM, SEL_ZOOM2_ROM};

  sel_vec_t              base_sel;
  logic [ZOOM_COUNT-1:0] zoom_hit;
  logic [ZOOM_COUNT-1:0] zoom_norm;
  logic [ZOOM_COUNT-1:0] zoom_rom;

  always_comb begin
    base_sel = '0;
    zoom_hit = '0;
    if (bus_valid) begin
      if (bus_addr < 16'h1000) begin
        base_sel[SEL_WRAM_FIX] = 1'b1;
      end else if (bus_addr < 16'h2000) begin
        if (!win_periph)              base_sel[SEL_WRAM_BANK] = 1'b1;
        else if (bus_addr < 16'h1800) zoom_hit[0] = 1'b1;
        else                          base_sel[SEL_PALETTE] = 1'b1;
      end else if (bus_addr <= 16'h2007) begin
        base_sel[SEL_SPR_CTRL] = 1'b1;
      end else if (bus_addr >= 16'h2400 && bus_addr < 16'h2800) begin
        base_sel[SEL_SPR_RAM] = 1'b1;
      end else if (bus_addr >= 16'h2800 && bus_addr < 16'h3000) begin
        zoom_hit[1] = 1'b1;
      end else if (bus_addr < 16'h4000) begin
        unique case (bus_addr)
          16'h3000: base_sel[SEL_SND_LATCH] = bus_we;
          16'h3001: base_sel[SEL_SND_IRQ]   = bus_we;
          16'h3002: base_sel[SEL_BANK_REG]  = bus_we;
          16'h3003: base_sel[SEL_VCTL_REG]  = bus_we;
          16'h3700: base_sel[SEL_AN_SEL]    = bus_we;
          16'h3701: base_sel[SEL_DIN]       = !bus_we;
          16'h3702: begin
            base_sel[SEL_AN_SEL]  = bus_we;
            base_sel[SEL_AN_DATA] = !bus_we;
          end
          default: ;
        endcase
      end else if (bus_addr < 16'h8000) begin
        base_sel[SEL_ROM_BANK] = !bus_we;
      end else begin
        base_sel[SEL_ROM_FIX] = !bus_we;
      end
    end
  end

  for (genvar g = 0; g < ZOOM_COUNT; g++) begin : g_zoom
    assign zoom_norm[g] = zoom_hit[g] & (bus_we | ~zoom_romrd);
    assign zoom_rom[g]  = zoom_hit[g] & ~bus_we & zoom_romrd;
  end

  always_comb begin
    sel = base_sel;
    for (int z = 0; z < ZOOM_COUNT; z++) begin
      sel[ZOOM_NORM_IDX[z]] = zoom_norm[z];
      sel[ZOOM_ROM_IDX[z]]  = zoom_rom[z];
    end
  end
endmodule

// File: rtl/mmd_rom_addr.sv
module mmd_rom_addr #(
  parameter int                  PAGE_BITS  = 5,
  parameter int                  SPAN_BITS  = 14,
  parameter int                  ROM_ADDR_W = 19,
  parameter logic [ROM_ADDR_W-1:0] FIX_BASE = 19'h48000
) (
  input  logic [PAGE_BITS-1:0]  page,
  input  logic [14:0]           addr_lo,
  input  logic                  use_bank,
  input  logic                  use_fix,
  output logic [ROM_ADDR_W-1:0] rom_addr
);
  logic [ROM_ADDR_W-1:0] bank_addr, fix_addr;

  assign bank_addr = ROM_ADDR_W'({page, addr_lo[SPAN_BITS-1:0]});
  assign fix_addr  = FIX_BASE + ROM_ADDR_W'(addr_lo);

  always_comb begin
    if (use_bank)     rom_addr = bank_addr;
    else if (use_fix) rom_addr = fix_addr;
    else              rom_addr = '0;
  end
endmodule

// File: rtl/memmap_bank_decoder.sv
module memmap_bank_decoder
  import mmd_pkg::*;
#(
  parameter int PAGE_BITS  = 5,
  parameter int PAGE_COUNT = 20,
  parameter int ROM_ADDR_W = 19
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  input  logic                  bus_we,
  input  logic [15:0]           bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [17:0]           dev_sel,
  output logic                  rd_strobe,
  output logic                  wr_strobe,
  output logic [ROM_ADDR_W-1:0] rom_addr,
  output logic                  open_bus_en,
  output logic [7:0]            open_bus_data,
  output logic [1:0]            coin_cnt
);
  localparam int WIN_BIT   = 5;
  localparam int ROMRD_BIT = 4;

  logic [PAGE_BITS-1:0] bank_page;
  logic                 win_periph;
  logic                 zoom_romrd;
  sel_vec_t             sel;
  logic                 any_sel;
  logic                 unused_wdata;

  assign unused_wdata = ^{bus_wdata[7:6], bus_wdata[3:2]};

  mmd_ctrl_regs #(
    .ADDR_W    (16),
    .PAGE_BITS (PAGE_BITS),
    .PAGE_COUNT(PAGE_COUNT)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .page_field  (bus_wdata[PAGE_BITS-1:0]),
    .win_field   (bus_wdata[WIN_BIT]),
    .coin_field  (bus_wdata[1:0]),
    .romrd_field (bus_wdata[ROMRD_BIT]),
    .page_q      (bank_page),
    .win_periph_q(win_periph),
    .zoom_romrd_q(zoom_romrd),
    .coin_q      (coin_cnt)
  );

  mmd_region_decode u_dec (
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .win_periph(win_periph),
    .zoom_romrd(zoom_romrd),
    .sel       (sel)
  );

  mmd_rom_addr #(
    .PAGE_BITS (PAGE_BITS),
    .SPAN_BITS (14),
    .ROM_ADDR_W(ROM_ADDR_W)
  ) u_rom (
    .page    (bank_page),
    .addr_lo (bus_addr[14:0]),
    .use_bank(sel[SEL_ROM_BANK]),
    .use_fix (sel[SEL_ROM_FIX]),
    .rom_addr(rom_addr)
  );

  assign dev_sel       = sel;
  assign any_sel       = |sel;
  assign rd_strobe     = any_sel & ~bus_we;
  assign wr_strobe     = any_sel & bus_we;
  assign open_bus_en   = bus_valid & ~bus_we & ~any_sel;
  assign open_bus_data = open_bus_en ? 8'hFF : 8'h00;
endmodule

// File: rtl/mmd_checker.sv
module mmd_checker #(
  parameter int PAGE_BITS  = 5,
  parameter int PAGE_COUNT = 20,
  parameter int ROM_ADDR_W = 19
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_valid,
  input logic                  bus_we,
  input logic [15:0]           bus_addr,
  input logic [7:0]            bus_wdata,
  input logic [17:0]           dev_sel,
  input logic                  rd_strobe,
  input logic                  wr_strobe,
  input logic [ROM_ADDR_W-1:0] rom_addr,
  input logic                  open_bus_en,
  input logic [7:0]            open_bus_data,
  input logic [1:0]            coin_cnt,
  input logic [PAGE_BITS-1:0]  page
);
  localparam logic [PAGE_BITS:0] LIMIT = (PAGE_BITS+1)'(PAGE_COUNT);

  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (dev_sel == '0 && !rd_strobe && !wr_strobe && !open_bus_en));

  a_r4_bad_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr == 16'h3002 &&
     {1'b0, bus_wdata[PAGE_BITS-1:0]} >= LIMIT) |=> $stable(page));

  a_r3_page_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel[16] |-> ({1'b0, rom_addr[ROM_ADDR_W-1:14]} < LIMIT));

  a_r7_coin_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr == 16'h3003) |=> coin_cnt == $past(bus_wdata[1:0]));

  a_r8_write_not_rom: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we) |-> (!dev_sel[3] && !dev_sel[8] && !rd_strobe));

  a_r12_open_bus: assert property (@(posedge clk) disable iff (!rst_n)
    open_bus_en |-> (dev_sel == '0 && open_bus_data == 8'hFF && !rd_strobe));

  a_r6_fixed_high: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel[17] |-> rom_addr >= ROM_ADDR_W'(19'h48000));
endmodule

bind memmap_bank_decoder mmd_checker #(
  .PAGE_BITS (PAGE_BITS),
  .PAGE_COUNT(PAGE_COUNT),
  .ROM_ADDR_W(ROM_ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .dev_sel      (dev_sel),
  .rd_strobe    (rd_strobe),
  .wr_strobe    (wr_strobe),
  .rom_addr     (rom_addr),
  .open_bus_en  (open_bus_en),
  .open_bus_data(open_bus_data),
  .coin_cnt     (coin_cnt),
  .page         (bank_page)
);

// File: tb/test_memmap_bank_decoder.sv
`timescale 1ns/1ps
module test_memmap_bank_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [17:0] dev_sel;
  logic        rd_strobe, wr_strobe;
  logic [18:0] rom_addr;
  logic        open_bus_en;
  logic [7:0]  open_bus_data;
  logic [1:0]  coin_cnt;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  int m_page = 0;
  bit m_win = 0;
  bit m_rom = 0;
  int m_coin = 0;

  always #5 clk = ~clk;

  memmap_bank_decoder i_memmap_bank_decoder (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dev_sel(dev_sel),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .rom_addr(rom_addr),
    .open_bus_en(open_bus_en), .open_bus_data(open_bus_data), .coin_cnt(coin_cnt)
  );

  function automatic int exp_idx(bit v, bit we, int a);
    if (!v) return -1;
    if (a < 'h1000) return 0;
    if (a < 'h2000) begin
      if (!m_win) return 1;
      if (a < 'h1800) return (m_rom && !we) ? 3 : 2;
      return 4;
    end
    if (a <= 'h2007) return 5;
    if (a >= 'h2400 && a < 'h2800) return 6;
    if (a >= 'h2800 && a < 'h3000) return (m_rom && !we) ? 8 : 7;
    if (a == 'h3000 && we) return 9;
    if (a == 'h3001 && we) return 10;
    if (a == 'h3002 && we) return 11;
    if (a == 'h3003 && we) return 12;
    if ((a == 'h3700 || a == 'h3702) && we) return 13;
    if (a == 'h3701 && !we) return 14;
    if (a == 'h3702 && !we) return 15;
    if (a >= 'h4000 && a < 'h8000 && !we) return 16;
    if (a >= 'h8000 && !we) return 17;
    return -1;
  endfunction

  task automatic cycle(bit v, bit we, int a, int d, string tag);
    int idx;
    logic [17:0] e_sel;
    logic [18:0] e_rom;
    bit e_open;
    bit bad;
    @(negedge clk);
    bus_valid = v; bus_we = we; bus_addr = 16'(a); bus_wdata = 8'(d);
    #2;
    idx = exp_idx(v, we, a);
    e_sel = (idx >= 0) ? (18'd1 << idx) : 18'd0;
    e_rom = (idx == 16) ? 19'(m_page * 'h4000 + (a - 'h4000)) :
            (idx == 17) ? 19'('h48000 + (a - 'h8000)) : 19'd0;
    e_open = v && !we && idx < 0;
    bad = 0;
    vectors++;
    if (dev_sel !== e_sel) begin
      bad = 1; $display("FAIL %s dev_sel @%h: got %h exp %h", tag, a, dev_sel, e_sel);
    end
    if (rom_addr !== e_rom) begin
      bad = 1; $display("FAIL %s rom_addr @%h: got %h exp %h", tag, a, rom_addr, e_rom);
    end
    if (rd_strobe !== (idx >= 0 && !we) || wr_strobe !== (idx >= 0 && we)) begin
      bad = 1; $display("FAIL %s strobes @%h: got rd%b wr%b exp rd%b wr%b", tag, a,
                        rd_strobe, wr_strobe, idx >= 0 && !we, idx >= 0 && we);
    end
    if (open_bus_en !== e_open || open_bus_data !== (e_open ? 8'hFF : 8'h00)) begin
      bad = 1; $display("FAIL %s open bus @%h: got %b/%h exp %b", tag, a,
                        open_bus_en, open_bus_data, e_open);
    end
    if (coin_cnt !== 2'(m_coin)) begin
      bad = 1; $display("FAIL %s coin_cnt: got %0d exp %0d", tag, coin_cnt, m_coin);
    end
    if (bad) miscompares++;
    @(posedge clk);
    #1;
    if (v && we && a == 'h3002) begin
      m_win = d[5];
      if ((d & 'h1f) < 20) m_page = d & 'h1f;
    end
    if (v && we && a == 'h3003) begin
      m_coin = d & 3;
      m_rom = d[4];
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state seen through the mapping
    cycle(1, 0, 'h4000, 0, "R1");
    cycle(1, 0, 'h1000, 0, "R1");
    cycle(1, 0, 'h2800, 0, "R1");
    cycle(0, 0, 'h0000, 0, "R1");
    // R2
    cycle(1, 0, 'h0000, 0, "R2");
    cycle(1, 1, 'h0FFF, 'h5A, "R2");
    // R3
    cycle(1, 1, 'h3002, 'h03, "R3");
    cycle(1, 0, 'h4000, 0, "R3");
    cycle(1, 0, 'h7FFF, 0, "R3");
    cycle(1, 1, 'h3002, 'h13, "R3");
    cycle(1, 0, 'h5234, 0, "R3");
    // R4
    cycle(1, 1, 'h3002, 'h14, "R4");
    cycle(1, 0, 'h4001, 0, "R4");
    cycle(1, 1, 'h3002, 'h1F, "R4");
    cycle(1, 0, 'h7FFE, 0, "R4");
    cycle(1, 1, 'h3002, 'hC2, "R4");
    cycle(1, 0, 'h4000, 0, "R4");
    cycle(1, 0, 'h1000, 0, "R4");
    // R5
    cycle(1, 1, 'h3002, 'h25, "R5");
    cycle(1, 0, 'h1000, 0, "R5");
    cycle(1, 1, 'h17FF, 'h11, "R5");
    cycle(1, 0, 'h1800, 0, "R5");
    cycle(1, 1, 'h1FFF, 'h22, "R5");
    cycle(1, 0, 'h0800, 0, "R5");
    cycle(1, 1, 'h3002, 'h34, "R4");
    cycle(1, 0, 'h6000, 0, "R4");
    cycle(1, 0, 'h1400, 0, "R5");
    // R6
    cycle(1, 0, 'h8000, 0, "R6");
    cycle(1, 0, 'hFFFF, 0, "R6");
    cycle(1, 0, 'hA5A5, 0, "R6");
    // R7
    cycle(1, 1, 'h3003, 'h03, "R7");
    cycle(1, 0, 'h0000, 0, "R7");
    cycle(1, 1, 'h3003, 'hE2, "R7");
    // R8
    cycle(1, 1, 'h3003, 'h12, "R8");
    cycle(1, 0, 'h1000, 0, "R8");
    cycle(1, 1, 'h1000, 'h01, "R8");
    cycle(1, 0, 'h2800, 0, "R8");
    cycle(1, 1, 'h2FFF, 'h02, "R8");
    cycle(1, 0, 'h1800, 0, "R8");
    cycle(1, 1, 'h3002, 'h05, "R8");
    cycle(1, 0, 'h1000, 0, "R8");
    cycle(1, 1, 'h3003, 'h00, "R8");
    cycle(1, 0, 'h2FFF, 0, "R8");
    // R9
    cycle(1, 0, 'h2000, 0, "R9");
    cycle(1, 1, 'h2007, 'h10, "R9");
    cycle(1, 0, 'h2400, 0, "R9");
    cycle(1, 1, 'h27FF, 'h20, "R9");
    // R10
    cycle(1, 1, 'h3000, 'h44, "R10");
    cycle(1, 1, 'h3001, 'h00, "R10");
    cycle(1, 1, 'h3700, 'h01, "R10");
    cycle(1, 0, 'h3701, 0, "R10");
    cycle(1, 0, 'h3702, 0, "R10");
    cycle(1, 1, 'h3702, 'h00, "R10");
    cycle(1, 0, 'h3000, 0, "R10");
    cycle(1, 1, 'h3701, 'h00, "R10");
    // R11
    cycle(0, 1, 'h3002, 'h07, "R11");
    cycle(1, 0, 'h4000, 0, "R11");
    cycle(0, 0, 'h8000, 0, "R11");
    // R12
    cycle(1, 0, 'h2008, 0, "R12");
    cycle(1, 0, 'h3004, 0, "R12");
    cycle(1, 0, 'h3100, 0, "R12");
    cycle(1, 1, 'h8000, 'h00, "R12");
    cycle(1, 1, 'h4000, 'h00, "R12");
    cycle(1, 0, 'h23FF, 0, "R12");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule